// File: doc/BRIEF.md
# Port Keyboard Interrupt Controller

This block turns the eight pins of one general-purpose port into keyboard interrupt sources. A per-pin enable register picks which pins take part. A two-flop synchroniser brings the pins into the bus clock domain. A low on any enabled pin counts as keyboard activity. When that activity starts, a pending flag is set, and the flag drives a single active-high interrupt request line.

Software uses two byte-wide registers on a simple bus. The bus has an address, a write strobe and write data, and read data comes back one cycle after the address. A control register selects the trigger mode and holds a mask. The mask holds off the request line but leaves the flag alone. The same register has a write-one acknowledge bit that clears the flag. In edge mode, only the start of activity sets the flag. In edge-plus-level mode, a pin that is still low keeps setting the flag again after each acknowledge.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register, flag, mask and mode are all 0, `irq_o` is 0, and both registers read 0x00.
- R2: The enable register is at address 0x0D. All 8 bits can be written and read back. Bit i enables pin i.
- R3: The control register is at address 0x0C. Its bits are: bit 3 = pending flag (read-only), bit 2 = acknowledge (write-only, reads 0), bit 1 = mask, bit 0 = mode (1 = edge plus level). Bits 7..4 read 0. Any other address reads 0x00.
- R4: Read data is registered. `bus_rdata_o` shows the register chosen by the address sampled at the previous clock edge, with its value before any write in that same cycle.
- R5: Keyboard activity means that at least one enabled pin, after the synchroniser, is low. In edge mode, activity going from absent to present sets the flag. It shows on `irq_o` after the third clock edge that samples the pin change.
- R6: A pin whose enable bit is 0 has no effect on the flag, however it toggles.
- R7: Writing the control register with bit 2 set clears the flag. A control write with bit 2 clear leaves the flag unchanged. In edge mode, the flag stays clear while enabled pins stay low.
- R8: In level mode, the flag sets on any clock where activity is present. After an acknowledge with a pin still low, the flag reads 0 for one cycle and then sets again.
- R9: Setting an enable bit while its pin is already low does not set the flag in edge mode.
- R10: A new falling edge seen in the same cycle as an acknowledge write wins, and the flag stays set.
- R11: `irq_o` is the flag gated by the inverted mask. Setting the mask never clears the flag, and clearing the mask later raises `irq_o` if the flag is still set.
- R12: A second enabled pin falling while another enabled pin is still low is not a new event in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| kbd_pins_i | input | NPINS (8) | Asynchronous port pins, active low |
| bus_addr_i | input | ADDR_W (8) | Register byte address |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | DATA_W (8) | Write data |
| bus_rdata_o | output | DATA_W (8) | Registered read data |
| irq_o | output | 1 | Keyboard interrupt request, active high |

## Verification
The hardest case to reach from the ports is an acknowledge write landing in exactly the clock where the synchronised falling edge is detected. That clock comes three edges after the pin moves. The stimulus first leaves the flag set, then drops a pin, then places the acknowledge write on the second falling clock edge after the pin change. A model that counts the synchroniser stages checks every clock that the flag survives. The level-mode one-cycle gap after an acknowledge is also narrow, and it is caught only by comparing `irq_o` on every cycle.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned KBD_CTRL_ADDR_DEF = 'h0C;
  localparam int unsigned KBD_EN_ADDR_DEF   = 'h0D;
  // Control register bit positions (software decodes these)
  localparam int unsigned FLAG_BIT = 3;
  localparam int unsigned ACK_BIT  = 2;
  localparam int unsigned MASK_BIT = 1;
  localparam int unsigned MODE_BIT = 0;

  typedef enum logic { TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1 } trig_mode_e;

  typedef struct packed {
    logic       mask;
    trig_mode_e mode;
  } kbd_ctrl_t;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/kbd_detect.sv
module kbd_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_s,
  input  logic [W-1:0] en,
  output logic         act,
  output logic         edge_det
);
  logic [W-1:0] pins_d;
  logic         prev_act;

  always_ff @(posedge clk) begin
    if (rst) pins_d <= '1;
    else     pins_d <= pins_s;
  end

  // Both activity terms use the present enables, so turning on an
  // enable over a pin that is already low produces no edge.
  assign act      = |(en & ~pins_s);
  assign prev_act = |(en & ~pins_d);
  assign edge_det = act & ~prev_act;
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_pkg::*;
#(
  parameter int unsigned NPINS     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = KBD_CTRL_ADDR_DEF,
  parameter int unsigned EN_ADDR   = KBD_EN_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              act,
  input  logic              edge_det,
  output logic [NPINS-1:0]  en_q,
  output logic              flag_q,
  output kbd_ctrl_t         ctrl_q,
  output logic              ack,
  output logic [DATA_W-1:0] rdata_q
);
  localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] EN_A   = EN_ADDR[ADDR_W-1:0];

  logic              wr_ctrl, wr_en;
  logic [DATA_W-1:0] rd_val;

  assign wr_ctrl = bus_wr && (bus_addr == CTRL_A);
  assign wr_en   = bus_wr && (bus_addr == EN_A);
  assign ack     = wr_ctrl && bus_wdata[ACK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      ctrl_q <= '{mask: 1'b0, mode: TRIG_EDGE};
    end else begin
      if (wr_en)   en_q <= bus_wdata[NPINS-1:0];
      if (wr_ctrl) begin
        ctrl_q.mask <= bus_wdata[MASK_BIT];
        ctrl_q.mode <= trig_mode_e'(bus_wdata[MODE_BIT]);
      end
    end
  end

  // Edge beats acknowledge; acknowledge beats level re-trigger.
  always_ff @(posedge clk) begin
    if (rst)                                      flag_q <= 1'b0;
    else if (edge_det)                            flag_q <= 1'b1;
    else if (ack)                                 flag_q <= 1'b0;
    else if (ctrl_q.mode == TRIG_LEVEL && act)    flag_q <= 1'b1;
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == CTRL_A) begin
      rd_val[FLAG_BIT] = flag_q;
      rd_val[MASK_BIT] = ctrl_q.mask;
      rd_val[MODE_BIT] = ctrl_q.mode;
    end else if (bus_addr == EN_A) begin
      rd_val[NPINS-1:0] = en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_val;
  end
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
  import kbd_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTRL_ADDR   = KBD_CTRL_ADDR_DEF,
  parameter int unsigned EN_ADDR     = KBD_EN_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  kbd_pins_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] pins_s;
  logic [NPINS-1:0] en_w;
  logic             act_w, edge_w, flag_w, ack_w;
  kbd_ctrl_t        ctrl_w;

  kbd_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (kbd_pins_i),
    .q   (pins_s)
  );

  kbd_detect #(.W(NPINS)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .pins_s   (pins_s),
    .en       (en_w),
    .act      (act_w),
    .edge_det (edge_w)
  );

  kbd_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .EN_ADDR(EN_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr_i),
    .bus_wr    (bus_wr_i),
    .bus_wdata (bus_wdata_i),
    .act       (act_w),
    .edge_det  (edge_w),
    .en_q      (en_w),
    .flag_q    (flag_w),
    .ctrl_q    (ctrl_w),
    .ack       (ack_w),
    .rdata_q   (bus_rdata_o)
  );

  assign irq_o = flag_w & ~ctrl_w.mask;
endmodule

// File: rtl/kbd_irq_chk.sv
module kbd_irq_chk
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = KBD_CTRL_ADDR_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] rdata,
  input logic              flag,
  input logic              mask,
  input logic              mode,
  input logic              ack,
  input logic              act,
  input logic              edge_det,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !edge_det) |=> !flag);
  // R10
  edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    edge_det |=> flag);
  // R8
  level_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && act && !ack) |=> flag);
  // R5
  no_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag && !edge_det && !(mode && act)) |=> !flag);
  // R11
  mask_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (mask && flag && !ack) |=> flag);
  // R11
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    mask |-> !irq);
  // R3
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == CTRL_A && !$past(rst)) |->
      ((rdata >> 4) == '0 && !rdata[ACK_BIT]));
endmodule

bind kbd_irq_ctrl kbd_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr_i),
  .rdata    (bus_rdata_o),
  .flag     (flag_w),
  .mask     (ctrl_w.mask),
  .mode     (ctrl_w.mode),
  .ack      (ack_w),
  .act      (act_w),
  .edge_det (edge_w),
  .irq      (irq_o)
);

// File: tb/test_kbd_irq_ctrl.sv
`timescale 1ns/1ps
module test_kbd_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pins = 8'hFF;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    done    = 0;

  always #5 clk = ~clk;

  kbd_irq_ctrl i_kbd_irq_ctrl (
    .clk(clk), .rst(rst), .kbd_pins_i(pins), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // Behavioural reference model
  logic [7:0] m_s1, m_s2, m_s3, m_en, m_rd;
  logic       m_flag, m_mask, m_mode;

  always @(posedge clk) begin
    logic a, pa, e, k;
    logic [7:0] r;
    started <= 1;
    if (rst) begin
      m_s1 = 8'hFF; m_s2 = 8'hFF; m_s3 = 8'hFF;
      m_en = 0; m_flag = 0; m_mask = 0; m_mode = 0; m_rd = 0;
    end else begin
      a  = (m_en & ~m_s2) != 0;
      pa = (m_en & ~m_s3) != 0;
      e  = a && !pa;
      k  = wr && addr == 8'h0C && wdata[2];
      if (addr == 8'h0C)      r = {4'b0, m_flag, 1'b0, m_mask, m_mode};
      else if (addr == 8'h0D) r = m_en;
      else                    r = 8'h00;
      m_rd = r;
      if (e)                m_flag = 1;
      else if (k)           m_flag = 0;
      else if (m_mode && a) m_flag = 1;
      if (wr && addr == 8'h0D) m_en = wdata;
      if (wr && addr == 8'h0C) begin m_mask = wdata[1]; m_mode = wdata[0]; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      vectors++;
      if (irq !== (m_flag & ~m_mask)) begin
        errors++;
        $display("FAIL %s: irq_o actual %b expected %b at %0t", cur_req, irq, m_flag & ~m_mask, $time);
      end
      vectors++;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h at %0t", cur_req, rdata, m_rd, $time);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #2; end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #2; addr = a; wdata = d; wr = 1;
    @(negedge clk); #2; wr = 0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // R4: address set, value appears after one edge
  task automatic rreg(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); #2; addr = a; wr = 0;
    @(negedge clk); check(req, rdata, exp); #2;
  endtask

  task automatic setpins(input logic [7:0] p);
    @(negedge clk); #2; pins = p;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tick(3); rst = 0;
    cur_req = "R1";
    check("R1 irq", {7'b0, irq}, 8'h00);
    rreg(8'h0C, 8'h00, "R1 ctrl");
    rreg(8'h0D, 8'h00, "R1 en");
    cur_req = "R3"; rreg(8'h0E, 8'h00, "R3 unmapped");

    cur_req = "R2";
    wreg(8'h0D, 8'hA5); rreg(8'h0D, 8'hA5, "R2 A5");
    wreg(8'h0D, 8'h5A); rreg(8'h0D, 8'h5A, "R2 5A");

    cur_req = "R3";
    wreg(8'h0C, 8'h07); rreg(8'h0C, 8'h03, "R3 ack reads 0");
    wreg(8'h0C, 8'hF0); rreg(8'h0C, 8'h00, "R3 upper bits");

    cur_req = "R4";
    @(negedge clk); #2; addr = 8'h0D; wdata = 8'h01; wr = 1;
    @(negedge clk); check("R4 old value", rdata, 8'h5A); #2; wr = 0;
    @(negedge clk); check("R4 new value", rdata, 8'h01); #2;

    cur_req = "R6";
    setpins(8'hFD); tick(4); setpins(8'hFF); tick(4);
    check("R6 irq", {7'b0, irq}, 8'h00);
    rreg(8'h0C, 8'h00, "R6 flag");

    cur_req = "R5";
    setpins(8'hFE); tick(1);
    check("R5 not yet", {7'b0, irq}, 8'h00);
    tick(2);
    check("R5 irq", {7'b0, irq}, 8'h01);
    rreg(8'h0C, 8'h08, "R5 flag");
    setpins(8'hFF); tick(3);

    cur_req = "R7";
    wreg(8'h0C, 8'h00); rreg(8'h0C, 8'h08, "R7 no-ack write");
    wreg(8'h0C, 8'h04); rreg(8'h0C, 8'h00, "R7 ack");
    setpins(8'hFE); tick(4); wreg(8'h0C, 8'h04); tick(4);
    rreg(8'h0C, 8'h00, "R7 edge mode stays clear");
    setpins(8'hFF); tick(3);

    cur_req = "R9";
    wreg(8'h0D, 8'h00); setpins(8'hFB); tick(4);
    wreg(8'h0D, 8'h04); tick(4);
    check("R9 irq", {7'b0, irq}, 8'h00);
    setpins(8'hFF); tick(4); setpins(8'hFB); tick(4);
    check("R9 real edge", {7'b0, irq}, 8'h01);
    wreg(8'h0C, 8'h04); setpins(8'hFF); tick(3);

    cur_req = "R12";
    wreg(8'h0D, 8'h03); setpins(8'hFE); tick(4);
    wreg(8'h0C, 8'h04); setpins(8'hFC); tick(5);
    check("R12 irq", {7'b0, irq}, 8'h00);
    setpins(8'hFF); tick(3);

    cur_req = "R11";
    wreg(8'h0C, 8'h02); setpins(8'hFE); tick(4);
    check("R11 masked irq", {7'b0, irq}, 8'h00);
    rreg(8'h0C, 8'h0A, "R11 flag kept");
    wreg(8'h0C, 8'h00); tick(1);
    check("R11 unmask", {7'b0, irq}, 8'h01);
    wreg(8'h0C, 8'h04); setpins(8'hFF); tick(3);

    cur_req = "R8";
    wreg(8'h0D, 8'h01); wreg(8'h0C, 8'h01); setpins(8'hFE); tick(4);
    check("R8 level", {7'b0, irq}, 8'h01);
    @(negedge clk); #2; addr = 8'h0C; wdata = 8'h05; wr = 1;
    @(negedge clk); check("R8 gap", {7'b0, irq}, 8'h00); #2; wr = 0;
    @(negedge clk); check("R8 re-set", {7'b0, irq}, 8'h01); #2;
    setpins(8'hFF); tick(3); wreg(8'h0C, 8'h05); tick(2);
    rreg(8'h0C, 8'h01, "R8 released");

    cur_req = "R10";
    wreg(8'h0C, 8'h00); setpins(8'hFE); tick(4); setpins(8'hFF); tick(4);
    setpins(8'hFE);
    @(negedge clk); #2;
    @(negedge clk); #2; addr = 8'h0C; wdata = 8'h04; wr = 1;
    @(negedge clk); #2; wr = 0;
    rreg(8'h0C, 8'h08, "R10 edge wins");
    check("R10 irq", {7'b0, irq}, 8'h01);
    setpins(8'hFF); tick(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule